// File: doc/BRIEF.md
# Byte-Serial Load/Store Sequencer

This block sits between a 16-bit register datapath and an 8-bit external memory bus that addresses 64K bytes. A request names an address, a direction, a size (byte or word) and, for stores, a 16-bit data value. The sequencer then runs the transfer one byte per clock. The bus has no wait or stall signal, so every byte cycle completes in the clock that issues it. Words sit in memory little-endian. A byte load is zero-extended into the 16-bit result.

Two options change the sequence. In absolute mode the request address points at two immediate bytes, which are fetched low byte first to form the real target address. The data transfer then follows. In post-increment mode the returned pointer is advanced past the data that was moved. A single-cycle done pulse marks the clock after the last byte cycle. The loaded value and the pointer are valid from that clock.

Top module: `bytebus_ldst`

## Requirements
- R1: After reset and while idle, busy, done, bus_rd and bus_wr are 0, and rdata and ptr_out read 0x0000. A reset taken during a transfer returns the block to this idle state at once.
- R2: Every clock in which busy is 1 carries exactly one byte cycle: either bus_rd or bus_wr is 1, never both. Neither strobe is active while busy is 0.
- R3: A word load reads address A and then A+1 on consecutive clocks, with addresses wrapping modulo 65536. The byte from A lands in rdata[7:0] and the byte from A+1 in rdata[15:8].
- R4: A byte load reads only address A and returns rdata = {8'h00, byte}.
- R5: A byte store performs a single write cycle at A that drives req_wdata[7:0] onto bus_wdata.
- R6: A word store writes req_wdata[7:0] at A and then req_wdata[15:8] at A+1 on the next clock.
- R7: In absolute mode the block first reads P and then P+1, where P is req_addr, to form target T = {byte(P+1), byte(P)}. The data transfer at T follows at once. An absolute word load therefore takes four bus cycles.
- R8: done is a one-clock pulse in the clock after the last byte cycle. rdata and ptr_out are valid from that clock and do not change while the block is idle without a new request.
- R9: ptr_out is T+2 after a post-increment word transfer, T+1 after a post-increment byte transfer, and T otherwise, taken modulo 65536.
- R10: req_valid is ignored while busy is 1. A request presented then causes no bus cycle and does not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_postinc | input | 1 | Return the pointer advanced past the data |
| req_absolute | input | 1 | Fetch a two-byte target address from req_addr first |
| req_addr | input | 16 | Data address, or pointer to the address bytes in absolute mode |
| req_wdata | input | 16 | Store data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock pulse after the last byte cycle |
| rdata | output | 16 | Assembled load result |
| ptr_out | output | 16 | Final (optionally incremented) pointer |
| bus_addr | output | 16 | Bus byte address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write byte |
| bus_rdata | input | 8 | Bus read byte, sampled at the end of a read cycle |

## Verification
The bench targets word accesses at 0xFFFF. A design that carried the address into a 17th bit or clamped it would put its second byte somewhere other than 0x0000, and would return a wrong ptr_out after post-increment. It checks byte loads over memory whose bytes have upper bits set, so a design that left stale data in rdata[15:8] shows a nonzero high byte. Absolute-mode cases check the exact order of bus addresses, which catches swapped immediate bytes or a data cycle issued before the address is complete. A request raised in the middle of a word load must leave no write on the bus and no change to the result. A reset in the middle of a transfer must silence the strobes at once.

// File: rtl/ldst_pkg.sv
// Shared types for the byte-serial load/store sequencer.
package ldst_pkg;
    // Sequencer phases: idle, two address-fetch beats, two data beats.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ALO  = 3'd1,
        ST_AHI  = 3'd2,
        ST_DLO  = 3'd3,
        ST_DHI  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/ldst_seq_ctrl.sv
// Phase controller. Latches the request mode bits on acceptance and steps
// through the byte beats, one per clock. Assumes the bus never stalls, so
// every beat completes in one clock.
module ldst_seq_ctrl
    import ldst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_word,
    input  logic       req_postinc,
    input  logic       req_absolute,
    output seq_state_t state,
    output logic       accept,
    output logic       op_write,
    output logic       op_word,
    output logic       op_postinc,
    output logic       last_beat,
    output logic       done
);
    seq_state_t state_nx;

    // Take a request only from idle.
    assign accept    = (state == ST_IDLE) && req_valid;
    // The final data beat depends on the transfer size.
    assign last_beat = ((state == ST_DLO) && !op_word) || (state == ST_DHI);

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = req_absolute ? ST_ALO : ST_DLO;
            ST_ALO:  state_nx = ST_AHI;
            ST_AHI:  state_nx = ST_DLO;
            ST_DLO:  state_nx = op_word ? ST_DHI : ST_IDLE;
            ST_DHI:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= last_beat;
        end
    end

    // Mode bits held for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write   <= 1'b0;
            op_word    <= 1'b0;
            op_postinc <= 1'b0;
        end else if (accept) begin
            op_write   <= req_write;
            op_word    <= req_word;
            op_postinc <= req_postinc;
        end
    end
endmodule

// File: rtl/ldst_addr_unit.sv
// Address generator. Holds the immediate-byte pointer and the target address,
// assembles the target from two fetched bytes in absolute mode, selects the
// byte address per beat and produces the returned pointer. Assumes the
// address is exactly two bus bytes wide; all arithmetic wraps.
module ldst_addr_unit
    import ldst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] bus_rdata,
    input  logic              op_word,
    input  logic              op_postinc,
    input  logic              last_beat,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] ptr_out
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    logic [ADDR_W-1:0] fetch_ptr;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] step;

    // Pointer advance for the transfer size.
    assign step = op_word ? TWO : ONE;

    // Byte address for the current beat.
    always_comb begin
        unique case (state)
            ST_ALO:  bus_addr = fetch_ptr;
            ST_AHI:  bus_addr = fetch_ptr + ONE;
            ST_DLO:  bus_addr = target;
            ST_DHI:  bus_addr = target + ONE;
            default: bus_addr = target;
        endcase
    end

    // Capture the request address and build the target in absolute mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_ptr <= '0;
            target    <= '0;
        end else if (accept) begin
            fetch_ptr <= req_addr;
            target    <= req_addr;
        end else if (state == ST_ALO) begin
            target[BYTE_W-1:0] <= bus_rdata;
        end else if (state == ST_AHI) begin
            target[ADDR_W-1:BYTE_W] <= bus_rdata[ADDR_W-BYTE_W-1:0];
        end
    end

    // Returned pointer, updated on the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_out <= '0;
        end else if (last_beat) begin
            ptr_out <= op_postinc ? target + step : target;
        end
    end
endmodule

// File: rtl/ldst_data_lane.sv
// Data lane. Buffers store data, selects the byte lane per beat and assembles
// loaded bytes little-endian, zero-filling the high byte on the first beat.
module ldst_data_lane
    import ldst_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              accept,
    input  logic              op_write,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] wbuf;

    // Low lane on the first data beat, high lane on the second.
    assign bus_wdata = (state == ST_DHI) ? wbuf[WORD_W-1:BYTE_W] : wbuf[BYTE_W-1:0];

    // Store-data buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)      wbuf <= '0;
        else if (accept) wbuf <= req_wdata;
    end

    // Load assembly: low byte with zero fill, then high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (!op_write && state == ST_DLO) begin
            rdata <= {{(WORD_W-BYTE_W){1'b0}}, bus_rdata};
        end else if (!op_write && state == ST_DHI) begin
            rdata[WORD_W-1:BYTE_W] <= bus_rdata;
        end
    end
endmodule

// File: rtl/bytebus_ldst.sv
// Top level of the byte-serial load/store sequencer. Converts one 16-bit
// load or store request into fixed one-clock byte cycles on an 8-bit bus,
// with an optional two-byte address fetch and pointer post-increment.
// Assumes the bus completes every cycle in one clock and returns read data
// before the end of the read clock.
module bytebus_ldst
    import ldst_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2 * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_word,
    input  logic                  req_postinc,
    input  logic                  req_absolute,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [2*BYTE_W-1:0]   req_wdata,
    output logic                  busy,
    output logic                  done,
    output logic [2*BYTE_W-1:0]   rdata,
    output logic [ADDR_W-1:0]     ptr_out,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic                  bus_rd,
    output logic                  bus_wr,
    output logic [BYTE_W-1:0]     bus_wdata,
    input  logic [BYTE_W-1:0]     bus_rdata
);
    localparam int WORD_W = 2 * BYTE_W;

    seq_state_t state;
    logic accept, op_write, op_word, op_postinc, last_beat;
    logic addr_beat, data_beat;

    ldst_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_word     (req_word),
        .req_postinc  (req_postinc),
        .req_absolute (req_absolute),
        .state        (state),
        .accept       (accept),
        .op_write     (op_write),
        .op_word      (op_word),
        .op_postinc   (op_postinc),
        .last_beat    (last_beat),
        .done         (done)
    );

    ldst_addr_unit #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .accept     (accept),
        .req_addr   (req_addr),
        .bus_rdata  (bus_rdata),
        .op_word    (op_word),
        .op_postinc (op_postinc),
        .last_beat  (last_beat),
        .bus_addr   (bus_addr),
        .ptr_out    (ptr_out)
    );

    ldst_data_lane #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .op_write  (op_write),
        .req_wdata (req_wdata),
        .bus_rdata (bus_rdata),
        .bus_wdata (bus_wdata),
        .rdata     (rdata)
    );

    // Strobe decode straight from the phase, so a beat costs no extra clock.
    assign addr_beat = (state == ST_ALO) || (state == ST_AHI);
    assign data_beat = (state == ST_DLO) || (state == ST_DHI);
    assign bus_rd    = addr_beat || (data_beat && !op_write);
    assign bus_wr    = data_beat && op_write;
    assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/bytebus_ldst_chk.sv
// Protocol checker for the sequencer, attached by bind. Observes ports only.
module bytebus_ldst_chk #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                busy,
    input logic                done,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [2*BYTE_W-1:0] rdata,
    input logic [ADDR_W-1:0]   ptr_out
);
    // R2: never a read and a write together.
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R2: every busy clock carries a byte cycle.
    p_busy_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bus_rd || bus_wr));

    // R2: the bus is quiet while idle.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr));

    // R8: done lasts one clock.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done follows a byte cycle.
    p_done_after_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_rd || bus_wr));

    // R8 / R9: results hold while idle without a request.
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> ($stable(rdata) && $stable(ptr_out)));
endmodule

bind bytebus_ldst bytebus_ldst_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .rdata     (rdata),
    .ptr_out   (ptr_out)
);

// File: tb/sim_bytebus_ldst.sv
module sim_bytebus_ldst;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic        req_postinc = 1'b0, req_absolute = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        busy, done, bus_rd, bus_wr;
    logic [15:0] rdata, ptr_out, bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [7:0]  mem [256];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytebus_ldst u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_postinc(req_postinc), .req_absolute(req_absolute),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .ptr_out(ptr_out), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Memory model: low 8 address bits select a byte; known fill on reset.
    assign bus_rdata = mem[bus_addr[7:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
        end else if (bus_wr) begin
            mem[bus_addr[7:0]] <= bus_wdata;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Stimulus vectors: {write, word, postinc, absolute, addr[15:0], wdata[15:0]}.
    localparam logic [35:0] VEC [NVEC] = '{
        {4'b0000, 16'h0010, 16'h0000},   // R4 byte load
        {4'b0100, 16'h0020, 16'h0000},   // R3 word load
        {4'b0110, 16'hFFFF, 16'h0000},   // R3 R9 wrap + postinc
        {4'b1000, 16'h0040, 16'hBEEF},   // R5 byte store
        {4'b1110, 16'h0050, 16'h1234},   // R6 R9 word store postinc
        {4'b0010, 16'hFFFF, 16'h0000},   // R9 byte postinc wrap
        {4'b0101, 16'h0080, 16'h0000},   // R7 absolute word load
        {4'b0001, 16'h00FE, 16'h0000},   // R7 absolute byte load
        {4'b1101, 16'h0090, 16'hCAFE},   // R7 absolute word store
        {4'b1100, 16'hFFFF, 16'h55AA}    // R6 word store wrap
    };

    // Run one request, comparing beats and results with a model built from the requirements.
    task automatic run_req(input logic wr, input logic wd, input logic pi, input logic ab,
                           input logic [15:0] a, input logic [15:0] wdat);
        logic [15:0] exp_addr [4];
        logic        exp_rd   [4];
        logic [7:0]  exp_wb   [4];
        logic [15:0] tgt, exp_rdata, exp_ptr;
        int n_exp, n, guard;
        n_exp = 0;
        tgt = a;
        if (ab) begin
            tgt = {mem[8'(a + 16'd1)], mem[a[7:0]]};
            exp_addr[0] = a;          exp_rd[0] = 1'b1; exp_wb[0] = 8'h00;
            exp_addr[1] = a + 16'd1;  exp_rd[1] = 1'b1; exp_wb[1] = 8'h00;
            n_exp = 2;
        end
        exp_addr[n_exp] = tgt; exp_rd[n_exp] = !wr; exp_wb[n_exp] = wdat[7:0];
        n_exp++;
        if (wd) begin
            exp_addr[n_exp] = tgt + 16'd1; exp_rd[n_exp] = !wr; exp_wb[n_exp] = wdat[15:8];
            n_exp++;
        end
        exp_rdata = wr ? rdata : (wd ? {mem[8'(tgt + 16'd1)], mem[tgt[7:0]]} : {8'h00, mem[tgt[7:0]]});
        exp_ptr = pi ? tgt + (wd ? 16'd2 : 16'd1) : tgt;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_postinc = pi;
        req_absolute = ab; req_addr = a; req_wdata = wdat;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; guard = 0;
        while (!done && guard < 8) begin
            if (bus_rd || bus_wr) begin
                if (n < 4) begin
                    chk("R3/R7 beat address", bus_addr, exp_addr[n]);
                    chk("R2 beat direction", {15'd0, bus_rd}, {15'd0, exp_rd[n]});
                    if (bus_wr) chk("R5/R6 write byte", {8'h00, bus_wdata}, {8'h00, exp_wb[n]});
                end
                n++;
            end
            guard++;
            @(negedge clk);
        end
        chk("R7 beat count", 16'(n), 16'(n_exp));
        chk("R8 done seen", {15'd0, done}, 16'd1);
        chk("R3/R4 rdata", rdata, exp_rdata);
        chk("R9 ptr_out", ptr_out, exp_ptr);
        @(negedge clk);
        chk("R8 done single pulse", {15'd0, done}, 16'd0);
        if (wr) begin
            chk("R5/R6 memory low byte", {8'h00, mem[tgt[7:0]]}, {8'h00, wdat[7:0]});
            if (wd) chk("R6 memory high byte", {8'h00, mem[8'(tgt + 16'd1)]}, {8'h00, wdat[15:8]});
        end
    endtask

    initial begin
        logic [15:0] held_r, held_p;
        logic [7:0]  probe;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 strobes", {14'd0, bus_rd, bus_wr}, 16'd0);
        chk("R1 rdata", rdata, 16'h0000);
        chk("R1 ptr_out", ptr_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle done", {15'd0, done}, 16'd0);

        // Vector table.
        for (int v = 0; v < NVEC; v++) begin
            run_req(VEC[v][35], VEC[v][34], VEC[v][33], VEC[v][32], VEC[v][31:16], VEC[v][15:0]);
        end

        // R8: results held over idle clocks.
        held_r = rdata; held_p = ptr_out;
        repeat (5) @(negedge clk);
        chk("R8 rdata held", rdata, held_r);
        chk("R8 ptr_out held", ptr_out, held_p);

        // R10: a store request raised mid-load is ignored.
        probe = mem[8'h33];
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_postinc = 1'b0;
        req_absolute = 1'b0; req_addr = 16'h0030; req_wdata = 16'h0000;
        @(negedge clk);
        req_write = 1'b1; req_addr = 16'h0033; req_wdata = 16'h0077;
        chk("R10 first beat is read", {15'd0, bus_rd}, 16'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 no write while busy", {15'd0, bus_wr}, 16'd0);
        chk("R10 second beat address", bus_addr, 16'h0031);
        @(negedge clk);
        chk("R10 done", {15'd0, done}, 16'd1);
        chk("R10 load result", rdata, {8'h31 ^ 8'hA5, 8'h30 ^ 8'hA5});
        chk("R10 no extra cycle", {14'd0, bus_rd, bus_wr}, 16'd0);
        chk("R10 memory untouched", {8'h00, mem[8'h33]}, {8'h00, probe});

        // R1: reset during a transfer.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1; req_absolute = 1'b1;
        req_addr = 16'h0010;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-transfer reset busy", {15'd0, busy}, 16'd0);
        chk("R1 mid-transfer reset strobes", {14'd0, bus_rd, bus_wr}, 16'd0);
        chk("R1 mid-transfer reset rdata", rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule